// File: doc/BRIEF.md
# Polled Floating-Point Bus Slave

This block places a single-precision floating-point engine behind a window of memory-mapped registers on an AHB bus. It never requests the bus. The processor writes two operands and then writes an operation code. That write launches the engine and raises a busy flag. The processor polls a status word until the operation finishes, then reads the result.

The engine is a pipeline with a fixed latency. It is reached through a one-cycle start pulse that carries the operation and both operands, and it answers with a valid pulse that carries the result. The wrapper does no arithmetic of its own. It decodes the address, pipelines the address phase into the data phase, holds the registers, and tracks the busy and done flags.

Top module: `fpu_ahb_slave`

## Requirements
- R1: A transfer is taken only when `hsel` and `hready` are high, `htrans` is NONSEQ (2'b10) or SEQ (2'b11), `hsize` is 3'b010 (word) and `haddr[31:20]` equals 12'h700. IDLE or BUSY transfers, other sizes, and addresses outside the window change no register.
- R2: Write data is taken from `hwdata` in the data phase that follows the address phase. Offset 0x00 holds operand A and offset 0x04 holds operand B, and both read back as written.
- R3: A write to offset 0x08 while idle stores the operation code from `hwdata[1:0]` (0 add, 1 subtract, 2 multiply, 3 divide). On the same clock edge it raises `eng_start` for exactly one cycle and sets status bit 0 (busy). `eng_op`, `eng_a` and `eng_b` carry the code and operands while `eng_start` is high.
- R4: When `eng_valid` arrives while busy, the wrapper latches `eng_result` into the result register at offset 0x10. On the same edge it clears busy and sets status bit 1 (done).
- R5: A read of offset 0x10 returns the latched result and clears done. A new launch also clears done.
- R6: A write to offset 0x08 while busy is ignored. It causes no start pulse, the stored code is unchanged when read back at 0x08, and the running operation's result is kept.
- R7: Any other offset inside the window reads as zero, and writes to it have no effect.
- R8: `hreadyout` is always high and `hresp` is always 0 (OKAY).
- R9: After reset, all registers read zero, status reads 0 and `eng_start` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Address-phase address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | Write when high |
| hsize | input | 3 | Transfer size |
| hwdata | input | 32 | Write data, data phase |
| hready | input | 1 | Previous transfer finished |
| hreadyout | output | 1 | Slave ready, always 1 |
| hresp | output | 1 | Response, always OKAY |
| hrdata | output | 32 | Read data, data phase |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_op | output | 2 | Operation code to the engine |
| eng_a | output | 32 | Operand A to the engine |
| eng_b | output | 32 | Operand B to the engine |
| eng_valid | input | 1 | Engine result valid |
| eng_result | input | 32 | Engine result word |

## Verification
Each of the four operation codes is tried with operand pairs whose results differ for every code. A wrong code passed to the engine, or operands swapped on the way, gives a wrong result. A second launch sent while busy tells a dropped write apart from one that replaced the code. Transfers that miss the window, are IDLE, or are the wrong size are sent with a distinct value and then read back to show that no register moved. Reads of status directly after a launch and after the result read show when busy and done are set and cleared.

// File: rtl/fpuw_pkg.sv
package fpuw_pkg;

  typedef enum logic [2:0] {
    RS_NONE = 3'd0,
    RS_OPA  = 3'd1,
    RS_OPB  = 3'd2,
    RS_OPC  = 3'd3,
    RS_STAT = 3'd4,
    RS_RES  = 3'd5
  } regsel_e;

  localparam logic [2:0] HSIZE_WORD = 3'b010;

  // Offset inside the window to register select; unaligned or unknown -> none
  function automatic regsel_e decode_off(input logic [31:0] off);
    regsel_e sel;
    case (off)
      32'h0000_0000: sel = RS_OPA;
      32'h0000_0004: sel = RS_OPB;
      32'h0000_0008: sel = RS_OPC;
      32'h0000_000C: sel = RS_STAT;
      32'h0000_0010: sel = RS_RES;
      default:       sel = RS_NONE;
    endcase
    return sel;
  endfunction

  // Active transfer of one full word
  function automatic logic xfer_ok(input logic [1:0] trans, input logic [2:0] size);
    return trans[1] && (size == HSIZE_WORD);
  endfunction

  function automatic logic [31:0] status_word(input logic busy, input logic done);
    return {30'd0, done, busy};
  endfunction

endpackage

// File: rtl/fpuw_addr_stage.sv
module fpuw_addr_stage
  import fpuw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 20,
  parameter logic [ADDR_W-WIN_BITS-1:0] BASE_HI = 12'h700
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsel,
  input  logic              hready,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  output logic              accept,
  output logic              dp_valid,
  output logic              dp_write,
  output regsel_e           dp_sel
);
  localparam int PAD_W = 32 - WIN_BITS;

  logic    in_window;
  regsel_e sel_now;

  assign in_window = (haddr[ADDR_W-1:WIN_BITS] == BASE_HI);
  assign accept    = hsel && hready && in_window && xfer_ok(htrans, hsize);
  assign sel_now   = decode_off({{PAD_W{1'b0}}, haddr[WIN_BITS-1:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_valid <= 1'b0;
      dp_write <= 1'b0;
      dp_sel   <= RS_NONE;
    end else if (hready) begin
      dp_valid <= accept;
      dp_write <= hwrite;
      dp_sel   <= sel_now;
    end
  end
endmodule

// File: rtl/fpuw_operands.sv
module fpuw_operands #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_a,
  input  logic              wr_b,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] op_a,
  output logic [DATA_W-1:0] op_b
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_a <= '0;
      op_b <= '0;
    end else begin
      if (wr_a) op_a <= wdata;
      if (wr_b) op_b <= wdata;
    end
  end
endmodule

// File: rtl/fpuw_ctrl.sv
module fpuw_ctrl #(
  parameter int DATA_W = 32,
  parameter int OP_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_opc,
  input  logic [OP_W-1:0]   wdata_op,
  input  logic              rd_res,
  input  logic              eng_valid,
  input  logic [DATA_W-1:0] eng_result,
  output logic              launch,
  output logic              finish,
  output logic [OP_W-1:0]   opcode,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              eng_start
);
  assign launch = wr_opc && !busy;
  assign finish = busy && eng_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode    <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      result    <= '0;
      eng_start <= 1'b0;
    end else begin
      eng_start <= launch;
      if (launch) begin
        opcode <= wdata_op;
        busy   <= 1'b1;
        done   <= 1'b0;
      end else if (finish) begin
        busy   <= 1'b0;
        done   <= 1'b1;
        result <= eng_result;
      end else if (rd_res) begin
        done   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fpu_ahb_slave.sv
module fpu_ahb_slave
  import fpuw_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 20,
  parameter logic [ADDR_W-WIN_BITS-1:0] BASE_HI = 12'h700,
  parameter int OP_W     = 2
) (
  input  logic              hclk,
  input  logic              hresetn,
  input  logic              hsel,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [1:0]        htrans,
  input  logic              hwrite,
  input  logic [2:0]        hsize,
  input  logic [DATA_W-1:0] hwdata,
  input  logic              hready,
  output logic              hreadyout,
  output logic              hresp,
  output logic [DATA_W-1:0] hrdata,
  output logic              eng_start,
  output logic [OP_W-1:0]   eng_op,
  output logic [DATA_W-1:0] eng_a,
  output logic [DATA_W-1:0] eng_b,
  input  logic              eng_valid,
  input  logic [DATA_W-1:0] eng_result
);
  logic    accept, dp_valid, dp_write;
  regsel_e dp_sel;
  logic    dp_wr, dp_rd;
  logic    wr_a, wr_b, wr_opc, rd_res;
  logic    launch, finish, busy, done;
  logic [OP_W-1:0]   opcode;
  logic [DATA_W-1:0] op_a, op_b, result;

  assign hreadyout = 1'b1;
  assign hresp     = 1'b0;

  fpuw_addr_stage #(
    .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .BASE_HI(BASE_HI)
  ) u_addr (
    .clk(hclk), .rst_n(hresetn), .hsel(hsel), .hready(hready),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
    .accept(accept), .dp_valid(dp_valid), .dp_write(dp_write), .dp_sel(dp_sel)
  );

  assign dp_wr  = dp_valid && dp_write && hready;
  assign dp_rd  = dp_valid && !dp_write;
  assign wr_a   = dp_wr && (dp_sel == RS_OPA);
  assign wr_b   = dp_wr && (dp_sel == RS_OPB);
  assign wr_opc = dp_wr && (dp_sel == RS_OPC);
  assign rd_res = dp_rd && hready && (dp_sel == RS_RES);

  fpuw_operands #(.DATA_W(DATA_W)) u_opnd (
    .clk(hclk), .rst_n(hresetn), .wr_a(wr_a), .wr_b(wr_b),
    .wdata(hwdata), .op_a(op_a), .op_b(op_b)
  );

  fpuw_ctrl #(.DATA_W(DATA_W), .OP_W(OP_W)) u_ctrl (
    .clk(hclk), .rst_n(hresetn), .wr_opc(wr_opc), .wdata_op(hwdata[OP_W-1:0]),
    .rd_res(rd_res), .eng_valid(eng_valid), .eng_result(eng_result),
    .launch(launch), .finish(finish), .opcode(opcode), .busy(busy),
    .done(done), .result(result), .eng_start(eng_start)
  );

  assign eng_op = opcode;
  assign eng_a  = op_a;
  assign eng_b  = op_b;

  always_comb begin
    hrdata = '0;
    if (dp_rd) begin
      case (dp_sel)
        RS_OPA:  hrdata = op_a;
        RS_OPB:  hrdata = op_b;
        RS_OPC:  hrdata = DATA_W'(opcode);
        RS_STAT: hrdata = DATA_W'(status_word(busy, done));
        RS_RES:  hrdata = result;
        default: hrdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/fpuw_checker.sv
module fpuw_checker (
  input logic clk,
  input logic rst_n,
  input logic hreadyout,
  input logic hresp,
  input logic eng_start,
  input logic eng_valid,
  input logic busy,
  input logic done,
  input logic rd_res
);
  // R8: ready and OKAY on every cycle
  p_ready_okay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hreadyout && !hresp);

  // R3: the start pulse coincides with busy being set
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);

  // R3: the start pulse is one cycle long
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  // R6: no launch while an operation is running
  p_no_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !eng_start);

  // R4: completion clears busy and sets done
  p_finish_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eng_valid) |=> (done && !busy));

  // R5: reading the result clears done
  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && !(busy && eng_valid)) |=> !done);

  // R4: busy and done never together
  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind fpu_ahb_slave fpuw_checker u_chk (
  .clk(hclk), .rst_n(hresetn), .hreadyout(hreadyout), .hresp(hresp),
  .eng_start(eng_start), .eng_valid(eng_valid), .busy(busy), .done(done),
  .rd_res(rd_res)
);

// File: tb/tb_fpu_ahb_slave.sv
module tb_fpu_ahb_slave;
  localparam int CLK_PERIOD = 10;
  localparam int ENG_LAT    = 5;
  localparam int NVEC       = 6;

  logic        hclk = 1'b0;
  logic        hresetn = 1'b0;
  logic        hsel = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'b010;
  logic [31:0] hwdata = '0;
  logic        hready = 1'b1;
  logic        hreadyout, hresp;
  logic [31:0] hrdata;
  logic        eng_start;
  logic [1:0]  eng_op;
  logic [31:0] eng_a, eng_b;
  logic        eng_valid;
  logic [31:0] eng_result;

  int tests = 0;
  int fails = 0;
  int starts = 0;
  int bus_err = 0;

  always #(CLK_PERIOD/2) hclk = ~hclk;

  fpu_ahb_slave dut (
    .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hready(hready),
    .hreadyout(hreadyout), .hresp(hresp), .hrdata(hrdata),
    .eng_start(eng_start), .eng_op(eng_op), .eng_a(eng_a), .eng_b(eng_b),
    .eng_valid(eng_valid), .eng_result(eng_result)
  );

  // Engine stand-in: fixed latency, simple integer formulas per code
  function automatic logic [31:0] stub_calc(input logic [1:0] op, input logic [31:0] a,
                                            input logic [31:0] b);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a * b;
      default: return a ^ b;
    endcase
  endfunction

  logic [ENG_LAT-1:0] pv = '0;
  logic [31:0]        pr [ENG_LAT];
  always_ff @(posedge hclk) begin
    pv <= {pv[ENG_LAT-2:0], eng_start};
    pr[0] <= stub_calc(eng_op, eng_a, eng_b);
    for (int i = 1; i < ENG_LAT; i++) pr[i] <= pr[i-1];
  end
  assign eng_valid  = pv[ENG_LAT-1];
  assign eng_result = pr[ENG_LAT-1];

  always @(posedge hclk) if (hresetn && eng_start) starts++;
  always @(negedge hclk) if (hresetn && (!hreadyout || hresp)) bus_err++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] addr, input logic wr, input logic [1:0] tr,
                      input logic [2:0] sz, input logic [31:0] wd, output logic [31:0] rd);
    @(negedge hclk);
    hsel = 1'b1; haddr = addr; htrans = tr; hwrite = wr; hsize = sz;
    @(negedge hclk);
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hsize = 3'b010; hwdata = wd;
    rd = hrdata;
  endtask

  task automatic wr32(input logic [31:0] addr, input logic [31:0] d);
    logic [31:0] junk;
    xfer(addr, 1'b1, 2'b10, 3'b010, d, junk);
  endtask

  task automatic rd32(input logic [31:0] addr, output logic [31:0] d);
    xfer(addr, 1'b0, 2'b10, 3'b010, 32'h0, d);
  endtask

  task automatic wait_idle(output logic [31:0] st);
    st = 32'h1;
    for (int k = 0; k < 40 && st[0]; k++) rd32(32'h7000_000C, st);
  endtask

  localparam logic [65:0] VEC [NVEC] = '{
    {2'd0, 32'h0000_1234, 32'h0000_0F0F},
    {2'd1, 32'h0000_1234, 32'h0000_0F0F},
    {2'd2, 32'h0000_1234, 32'h0000_0F0F},
    {2'd3, 32'h0000_1234, 32'h0000_0F0F},
    {2'd1, 32'h0000_0001, 32'h0000_0002},
    {2'd2, 32'hFFFF_FFFF, 32'h8000_0001}
  };

  initial begin
    repeat (200000) @(posedge hclk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, st;
    logic [1:0]  op;
    logic [31:0] a, b;
    int s0;
    repeat (3) @(posedge hclk);
    @(negedge hclk) hresetn = 1'b1;

    // R9 reset state
    check("R9 start low", {31'd0, eng_start}, 32'h0);
    rd32(32'h7000_000C, v); check("R9 status", v, 32'h0);
    rd32(32'h7000_0000, v); check("R9 operand A", v, 32'h0);
    rd32(32'h7000_0010, v); check("R9 result", v, 32'h0);

    // Vector walk: R2, R3, R4, R5
    for (int i = 0; i < NVEC; i++) begin
      {op, a, b} = VEC[i];
      wr32(32'h7000_0000, a);
      wr32(32'h7000_0004, b);
      rd32(32'h7000_0000, v); check("R2 operand A", v, a);
      rd32(32'h7000_0004, v); check("R2 operand B", v, b);
      wr32(32'h7000_0008, {30'd0, op});
      rd32(32'h7000_000C, v); check("R3 busy after launch", v, 32'h1);
      wait_idle(st);
      check("R4 done set", st, 32'h2);
      rd32(32'h7000_0010, v); check("R4 result", v, stub_calc(op, a, b));
      rd32(32'h7000_000C, v); check("R5 done cleared", v, 32'h0);
      rd32(32'h7000_0008, v); check("R3 code readback", v, {30'd0, op});
    end
    check("R3 one start per launch", starts, NVEC);

    // R6: second launch while busy is dropped
    s0 = starts;
    wr32(32'h7000_0000, 32'd10);
    wr32(32'h7000_0004, 32'd3);
    wr32(32'h7000_0008, 32'd0);
    wr32(32'h7000_0008, 32'd2);
    wait_idle(st);
    check("R6 single start", starts - s0, 1);
    rd32(32'h7000_0008, v); check("R6 code kept", v, 32'h0);
    rd32(32'h7000_0010, v); check("R6 result of first op", v, 32'd13);

    // R5: new launch clears done without a result read
    wr32(32'h7000_0008, 32'd1);
    wait_idle(st); check("R5 done before launch", st, 32'h2);
    wr32(32'h7000_0008, 32'd2);
    rd32(32'h7000_000C, v); check("R5 launch clears done", v, 32'h1);
    wait_idle(st);
    rd32(32'h7000_0010, v); check("R5 result", v, 32'd30);

    // R1: ignored transfers
    wr32(32'h7000_0000, 32'hAAAA_0001);
    xfer(32'h7000_0000, 1'b1, 2'b00, 3'b010, 32'h1111_1111, v);
    xfer(32'h7000_0000, 1'b1, 2'b01, 3'b010, 32'h2222_2222, v);
    xfer(32'h7000_0000, 1'b1, 2'b10, 3'b000, 32'h3333_3333, v);
    xfer(32'h7010_0000, 1'b1, 2'b10, 3'b010, 32'h4444_4444, v);
    xfer(32'h6000_0000, 1'b1, 2'b10, 3'b010, 32'h5555_5555, v);
    @(negedge hclk);
    haddr = 32'h7000_0000; htrans = 2'b10; hwrite = 1'b1; hsel = 1'b0;
    @(negedge hclk);
    htrans = 2'b00; hwrite = 1'b0; hwdata = 32'h6666_6666;
    rd32(32'h7000_0000, v); check("R1 ignored transfers", v, 32'hAAAA_0001);
    xfer(32'h7000_0004, 1'b1, 2'b11, 3'b010, 32'h0BAD_F00D, v);
    rd32(32'h7000_0004, v); check("R1 SEQ accepted", v, 32'h0BAD_F00D);
    xfer(32'h7000_0008, 1'b1, 2'b00, 3'b010, 32'h3, v);
    rd32(32'h7000_000C, v); check("R1 IDLE no launch", v, 32'h0);

    // R7: unmapped offsets
    wr32(32'h7000_0014, 32'hDEAD_BEEF);
    wr32(32'h700F_FFF0, 32'hDEAD_BEEF);
    rd32(32'h7000_0014, v); check("R7 unmapped read", v, 32'h0);
    rd32(32'h7008_0000, v); check("R7 far offset read", v, 32'h0);
    rd32(32'h7000_0000, v); check("R7 A untouched", v, 32'hAAAA_0001);
    rd32(32'h7000_0004, v); check("R7 B untouched", v, 32'h0BAD_F00D);

    // R8: handshake outputs stayed ready/OKAY throughout
    check("R8 ready okay cycles bad", bus_err, 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule